// File: doc/BRIEF.md
# Bi-Mode Conditional Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each cycle the fetch stage may present a branch address together with a flag saying whether the branch hit in the target buffer and a flag saying whether its displacement is negative. One cycle later the block returns a taken or not-taken decision and the history value that was current when the prediction was made. The branch carries that history value down the pipeline as its checkpoint.

Direction state lives in two banks of two-bit saturating counters. One bank is biased toward taken and the other toward not taken. Both are indexed by the branch address XOR the global history. A third table of two-bit counters, indexed by the address alone, picks which bank answers for each branch. Branches that are biased in opposite directions then land in different banks and no longer wear down each other's counters. A branch with no target-buffer entry gets a static decision instead: backward branches are taken, forward branches are not.

The global history is shifted with every prediction, before the branch resolves. Branches may resolve in any order. When a resolution reports a misprediction, the history is rebuilt from the branch's checkpoint plus its real outcome in the very next cycle, so the wrong-path history is discarded at once. Every resolution also trains the tables.

Top module: `bm_predictor`

## Requirements
- R1: While `rst_n` is low, `pred_valid_o` is 0 in the following cycle. After reset the global history is all zeros, so the first reported checkpoint is 0.
- R2: A request (`req_valid_i` = 1) produces exactly one result cycle with `pred_valid_o` = 1, in the cycle after the request. A cycle with no request produces `pred_valid_o` = 0 in the next cycle.
- R3: With `req_target_hit_i` = 0, the prediction is `req_backward_i`: 1 (taken) for a negative displacement and 0 (not taken) otherwise. The tables have no say.
- R4: With `req_target_hit_i` = 1, the choice counter at index `pc[IDX_W+1:2]` picks the bank. A counter MSB of 1 picks the taken-biased bank and 0 picks the not-taken-biased bank. The prediction is the MSB of that bank's counter at index `pc[IDX_W+1:2] XOR history`.
- R5: Every request shifts the history left by one. The predicted direction enters at bit 0, where 1 means taken. `pred_hist_o` reports the history as it stood before this shift.
- R6: A resolution with `res_mispred_i` = 1 sets the history to `{res_hist_i[IDX_W-2:0], res_taken_i}` in the next cycle. This overrides the shift from a request in the same cycle. A resolution without a misprediction leaves the history unchanged.
- R7: A resolution trains only the bank that the choice counter currently selects. It uses the entry at `res_pc_i[IDX_W+1:2] XOR res_hist_i` and moves it one step toward the outcome. The other bank is not written.
- R8: The choice counter moves one step toward the outcome, with one exception. When the choice counter's MSB disagrees with the outcome but the selected bank counter's MSB matched the outcome, the choice counter is left unchanged.
- R9: All counters saturate, never going below 0 or above 3.
- R10: After reset, every choice counter holds 1 (weakly selecting the not-taken bank). Every taken-bank counter holds 2 (weakly taken) and every not-taken-bank counter holds 1 (weakly not taken).
- R11: Table reads for a request see the contents from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Prediction request strobe |
| req_pc_i | input | PC_W | Branch address to predict |
| req_target_hit_i | input | 1 | Branch hit in the target buffer |
| req_backward_i | input | 1 | Branch displacement is negative |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | IDX_W | History checkpoint for this branch |
| res_valid_i | input | 1 | Resolution strobe |
| res_pc_i | input | PC_W | Address of the resolved branch |
| res_taken_i | input | 1 | Actual direction, 1 = taken |
| res_mispred_i | input | 1 | The branch was mispredicted |
| res_hist_i | input | IDX_W | Checkpoint captured when the branch was predicted |

## Verification
The history assertions have two blind spots they rely on the inputs to cover.
- They take the checkpoint on `res_hist_i` as opaque. Any value is accepted, and the assertions do not check that it matches an earlier `pred_hist_o`.
- They assume `res_mispred_i` only matters while `res_valid_i` is high.

The stimulus stays inside both assumptions. Directed resolutions carry chosen checkpoints so the history can be steered to known values. Random resolutions draw arbitrary checkpoints, outcomes and misprediction flags. The address range is kept small so that choice and bank entries alias often. It also produces same-cycle requests and resolutions on shared entries, which exercises both the read-before-write behaviour and the override of the speculative shift.

// File: rtl/bm_pkg.sv
// Shared types and helpers for the bi-mode direction predictor.
// Assumes two-bit counters where MSB = 1 means "taken" (or "taken bank").
package bm_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'b01;
    localparam ctr_t CTR_WEAK_T  = 2'b10;

    // One saturating step of a two-bit counter toward the given direction.
    function automatic ctr_t sat_step(input ctr_t c, input logic up);
        ctr_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction
endpackage

// File: rtl/bm_ctr_table.sv
// Array of two-bit counters with two asynchronous read ports and one write port.
// Assumes reads return pre-write contents; all entries reset to INIT.
module bm_ctr_table
    import bm_pkg::*;
#(
    parameter int   IDX_W = 10,
    parameter ctr_t INIT  = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr_t             rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr_t             rd_b_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_t             wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    // Read ports: combinational lookup of current contents.
    always_comb begin
        rd_a_val = mem[rd_a_idx];
        rd_b_val = mem[rd_b_idx];
    end

    // Storage: reset every entry to INIT, else apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/bm_ghr.sv
// Global branch history register with speculative shift and checkpoint repair.
// Assumes repair has priority over a same-cycle speculative shift.
module bm_ghr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spec_en,
    input  logic         spec_bit,
    input  logic         fix_en,
    input  logic [W-1:0] fix_hist,
    input  logic         fix_bit,
    output logic [W-1:0] hist_o
);
    logic [W-1:0] hist_q;

    // History update: repair wins, otherwise shift in the predicted bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       hist_q <= '0;
        else if (fix_en)  hist_q <= {fix_hist[W-2:0], fix_bit};
        else if (spec_en) hist_q <= {hist_q[W-2:0], spec_bit};
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/bm_train.sv
// Resolution-time training decisions for the bi-mode predictor.
// Assumes choice/bank values are the pre-update contents for the resolved branch.
module bm_train
    import bm_pkg::*;
(
    input  logic       res_valid,
    input  logic       taken,
    input  ctr_t       choice_cur,
    input  ctr_t       bank_nt_cur,
    input  ctr_t       bank_t_cur,
    output logic       choice_we,
    output ctr_t       choice_nxt,
    output logic [1:0] bank_we,
    output ctr_t       bank_nxt
);
    logic sel_t;
    ctr_t sel_ctr;
    logic bank_right;
    logic choice_wrong;

    // Decide which bank trains and whether the choice counter moves.
    always_comb begin
        sel_t        = choice_cur[1];
        sel_ctr      = sel_t ? bank_t_cur : bank_nt_cur;
        bank_right   = (sel_ctr[1] == taken);
        choice_wrong = (choice_cur[1] != taken);
        bank_nxt     = sat_step(sel_ctr, taken);
        bank_we      = res_valid ? (sel_t ? 2'b10 : 2'b01) : 2'b00;
        choice_nxt   = sat_step(choice_cur, taken);
        choice_we    = res_valid && !(choice_wrong && bank_right);
    end
endmodule

// File: rtl/bm_predictor.sv
// Bi-mode conditional branch direction predictor (top).
// One-cycle prediction latency; static backward-taken rule on target-buffer miss;
// speculative history with checkpoint repair on misprediction.
// Assumes PC bits [1:0] are instruction alignment and ignored.
module bm_predictor
    import bm_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [PC_W-1:0]  req_pc_i,
    input  logic             req_target_hit_i,
    input  logic             req_backward_i,
    output logic             pred_valid_o,
    output logic             pred_taken_o,
    output logic [IDX_W-1:0] pred_hist_o,
    input  logic             res_valid_i,
    input  logic [PC_W-1:0]  res_pc_i,
    input  logic             res_taken_i,
    input  logic             res_mispred_i,
    input  logic [IDX_W-1:0] res_hist_i
);
    localparam int NBANK = 2;

    logic [IDX_W-1:0] hist_q;
    logic [IDX_W-1:0] req_cidx, req_didx, res_cidx, res_didx;
    ctr_t             choice_req, choice_res, choice_nxt, bank_nxt;
    ctr_t             bank_req [NBANK];
    ctr_t             bank_res [NBANK];
    logic [NBANK-1:0] bank_we;
    logic             choice_we;
    logic             dyn_taken, taken_now, recover;

    // Index formation for request and resolution sides.
    always_comb begin
        req_cidx = req_pc_i[IDX_W+1:2];
        req_didx = req_cidx ^ hist_q;
        res_cidx = res_pc_i[IDX_W+1:2];
        res_didx = res_cidx ^ res_hist_i;
    end

    bm_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_choice (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(req_cidx), .rd_a_val(choice_req),
        .rd_b_idx(res_cidx), .rd_b_val(choice_res),
        .wr_en(choice_we), .wr_idx(res_cidx), .wr_val(choice_nxt)
    );

    // Bank 0 is not-taken biased, bank 1 is taken biased.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam ctr_t BANK_INIT = (g == 1) ? CTR_WEAK_T : CTR_WEAK_NT;
        bm_ctr_table #(.IDX_W(IDX_W), .INIT(BANK_INIT)) u_tbl (
            .clk(clk), .rst_n(rst_n),
            .rd_a_idx(req_didx), .rd_a_val(bank_req[g]),
            .rd_b_idx(res_didx), .rd_b_val(bank_res[g]),
            .wr_en(bank_we[g]), .wr_idx(res_didx), .wr_val(bank_nxt)
        );
    end

    bm_train u_train (
        .res_valid(res_valid_i), .taken(res_taken_i),
        .choice_cur(choice_res), .bank_nt_cur(bank_res[0]), .bank_t_cur(bank_res[1]),
        .choice_we(choice_we), .choice_nxt(choice_nxt),
        .bank_we(bank_we), .bank_nxt(bank_nxt)
    );

    // Direction select: chosen bank MSB on hit, static displacement rule on miss.
    always_comb begin
        dyn_taken = choice_req[1] ? bank_req[1][1] : bank_req[0][1];
        taken_now = req_target_hit_i ? dyn_taken : req_backward_i;
        recover   = res_valid_i && res_mispred_i;
    end

    bm_ghr #(.W(IDX_W)) u_ghr (
        .clk(clk), .rst_n(rst_n),
        .spec_en(req_valid_i), .spec_bit(taken_now),
        .fix_en(recover), .fix_hist(res_hist_i), .fix_bit(res_taken_i),
        .hist_o(hist_q)
    );

    // Result register: one-cycle prediction latency with checkpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid_o <= 1'b0;
            pred_taken_o <= 1'b0;
            pred_hist_o  <= '0;
        end else begin
            pred_valid_o <= req_valid_i;
            if (req_valid_i) begin
                pred_taken_o <= taken_now;
                pred_hist_o  <= hist_q;
            end
        end
    end
endmodule

// File: rtl/bm_predictor_chk.sv
// Assertion checker for bm_predictor, attached by bind.
module bm_predictor_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             req_target_hit_i,
    input logic             req_backward_i,
    input logic             pred_valid_o,
    input logic             pred_taken_o,
    input logic [IDX_W-1:0] pred_hist_o,
    input logic             res_valid_i,
    input logic             res_taken_i,
    input logic             res_mispred_i,
    input logic [IDX_W-1:0] res_hist_i,
    input logic [IDX_W-1:0] hist_q
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !pred_valid_o);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> pred_valid_o);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !pred_valid_o);

    a_r3_static_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_target_hit_i) |=> (pred_taken_o == $past(req_backward_i)));

    a_r5_checkpoint_prior: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (pred_hist_o == $past(hist_q)));

    a_r5_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(res_valid_i && res_mispred_i))
        |=> (hist_q == {pred_hist_o[IDX_W-2:0], pred_taken_o}));

    a_r6_repair: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && res_mispred_i)
        |=> (hist_q == {$past(res_hist_i[IDX_W-2:0]), $past(res_taken_i)}));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid_i && !(res_valid_i && res_mispred_i)) |=> $stable(hist_q));
endmodule

bind bm_predictor bm_predictor_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_target_hit_i(req_target_hit_i),
    .req_backward_i(req_backward_i),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
    .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
    .res_mispred_i(res_mispred_i), .res_hist_i(res_hist_i),
    .hist_q(hist_q)
);

// File: tb/bm_predictor_tb.sv
`timescale 1ns/1ps
module bm_predictor_tb;
    localparam int PC_W  = 32;
    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [PC_W-1:0]  req_pc_i = '0;
    logic             req_target_hit_i = 1'b0;
    logic             req_backward_i = 1'b0;
    logic             pred_valid_o;
    logic             pred_taken_o;
    logic [IDX_W-1:0] pred_hist_o;
    logic             res_valid_i = 1'b0;
    logic [PC_W-1:0]  res_pc_i = '0;
    logic             res_taken_i = 1'b0;
    logic             res_mispred_i = 1'b0;
    logic [IDX_W-1:0] res_hist_i = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bm_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (.*);

    // Reference state built from the requirements.
    logic [1:0]       m_choice [DEPTH];
    logic [1:0]       m_bnt    [DEPTH];
    logic [1:0]       m_bt     [DEPTH];
    logic [IDX_W-1:0] m_hist;

    bit               q_taken [$];
    logic [IDX_W-1:0] q_hist  [$];
    string            q_tag   [$];

    function automatic logic [1:0] step(input logic [1:0] c, input bit up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    // Driver: one cycle of stimulus plus the model update for that edge.
    task automatic cyc(input bit rv, input logic [PC_W-1:0] pc, input bit hit, input bit back,
                       input bit sv, input logic [PC_W-1:0] spc, input bit st, input bit smis,
                       input logic [IDX_W-1:0] sh, input string tag);
        logic [IDX_W-1:0] ci, di;
        bit pt, sel, ok, cwrong;
        logic [1:0] sc;
        @(negedge clk);
        req_valid_i = rv; req_pc_i = pc; req_target_hit_i = hit; req_backward_i = back;
        res_valid_i = sv; res_pc_i = spc; res_taken_i = st; res_mispred_i = smis; res_hist_i = sh;
        pt = 1'b0;
        if (rv) begin
            ci = pc[IDX_W+1:2];
            di = ci ^ m_hist;
            if (hit) pt = m_choice[ci][1] ? m_bt[di][1] : m_bnt[di][1];
            else     pt = back;
            q_taken.push_back(pt); q_hist.push_back(m_hist); q_tag.push_back(tag);
        end
        if (sv) begin
            ci = spc[IDX_W+1:2];
            di = ci ^ sh;
            sel = m_choice[ci][1];
            sc = sel ? m_bt[di] : m_bnt[di];
            ok = (sc[1] == st);
            cwrong = (m_choice[ci][1] != st);
            if (sel) m_bt[di] = step(sc, st); else m_bnt[di] = step(sc, st);
            if (!(cwrong && ok)) m_choice[ci] = step(m_choice[ci], st);
        end
        if (sv && smis) m_hist = {sh[IDX_W-2:0], st};
        else if (rv)    m_hist = {m_hist[IDX_W-2:0], pt};
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, 0, '0, 0, 0, '0, "idle");
    endtask

    task automatic pred(input logic [PC_W-1:0] pc, input bit hit, input bit back, input string tag);
        cyc(1, pc, hit, back, 0, '0, 0, 0, '0, tag);
    endtask

    task automatic resolve(input logic [PC_W-1:0] pc, input bit t, input bit mis,
                           input logic [IDX_W-1:0] h, input string tag);
        cyc(0, '0, 0, 0, 1, pc, t, mis, h, tag);
    endtask

    // Steer history to value hv through a mispredict repair.
    task automatic set_hist(input logic [IDX_W-1:0] hv);
        resolve(32'h0000_3F00, hv[0], 1, {1'b0, hv[IDX_W-1:1]}, "R6");
    endtask

    // Monitor: compare each produced prediction against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !finished && pred_valid_o) begin
            if (q_taken.size() == 0) begin
                errors++; checks++;
                $display("FAIL R2 unexpected pred_valid_o act=1 exp=0");
            end else begin
                bit et; logic [IDX_W-1:0] eh; string tg;
                et = q_taken.pop_front(); eh = q_hist.pop_front(); tg = q_tag.pop_front();
                checks++;
                if (pred_taken_o !== et) begin
                    errors++;
                    $display("FAIL %s taken act=%0b exp=%0b", tg, pred_taken_o, et);
                end
                checks++;
                if (pred_hist_o !== eh) begin
                    errors++;
                    $display("FAIL %s hist act=%0h exp=%0h", tg, pred_hist_o, eh);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog act=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_choice[i] = 2'd1; m_bnt[i] = 2'd1; m_bt[i] = 2'd2;
        end
        m_hist = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pred_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 pred_valid_o in reset act=%0b exp=0", pred_valid_o);
        end
        rst_n = 1'b1;
        idle();
        checks++;
        if (pred_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle pred_valid_o act=%0b exp=0", pred_valid_o);
        end

        // R1/R10: first dynamic prediction uses reset counters, checkpoint 0.
        pred(32'h0000_0100, 1, 0, "R1");
        pred(32'h0000_0104, 1, 1, "R10");
        // R3: static rule on target miss.
        pred(32'h0000_0200, 0, 1, "R3");
        pred(32'h0000_0204, 0, 0, "R3");
        pred(32'h0000_0208, 0, 1, "R3");
        idle();
        // R5: back-to-back predictions build history.
        for (int i = 0; i < 6; i++) pred(32'h0000_0300 + 4 * i, 0, i[0], "R5");
        idle();
        // R6: repair, then check checkpoint; correct resolution keeps history.
        set_hist(10'h2A5);
        pred(32'h0000_0400, 0, 0, "R6");
        resolve(32'h0000_0400, 0, 0, 10'h155, "R6");
        pred(32'h0000_0404, 0, 1, "R6");
        // R6: repair overrides same-cycle speculative shift.
        cyc(1, 32'h0000_0408, 0, 1, 1, 32'h0000_0408, 0, 1, 10'h0F0, "R6");
        pred(32'h0000_040C, 0, 0, "R6");
        idle();

        // R7/R8/R4: train one branch under a fixed history and read it back.
        for (int i = 0; i < 3; i++) resolve(32'h0000_0500, 1, 1, 10'h011, "R7");
        set_hist(10'h011);
        pred(32'h0000_0500, 1, 0, "R4");
        resolve(32'h0000_0500, 0, 1, 10'h011, "R8");
        set_hist(10'h011);
        pred(32'h0000_0500, 1, 0, "R8");
        // Same choice entry, other history: untouched bank entry still reset value.
        set_hist(10'h3C3);
        pred(32'h0000_0500, 1, 0, "R7");
        idle();

        // R9: saturation both ways.
        for (int i = 0; i < 6; i++) resolve(32'h0000_0600, 1, 0, 10'h000, "R9");
        set_hist(10'h000);
        pred(32'h0000_0600, 1, 0, "R9");
        for (int i = 0; i < 6; i++) resolve(32'h0000_0600, 0, 0, 10'h000, "R9");
        set_hist(10'h000);
        pred(32'h0000_0600, 1, 0, "R9");
        resolve(32'h0000_0600, 1, 0, 10'h000, "R9");
        set_hist(10'h000);
        pred(32'h0000_0600, 1, 0, "R9");

        // R11: same-cycle request and resolution on the same entries.
        set_hist(10'h000);
        cyc(1, 32'h0000_0700, 1, 0, 1, 32'h0000_0700, 1, 0, 10'h000, "R11");
        idle();

        // Mixed traffic with heavy aliasing (R4, R7, R8).
        for (int n = 0; n < 3000; n++) begin
            cyc($urandom_range(0, 1), 32'($urandom_range(0, 255)) << 2, $urandom_range(0, 3) != 0,
                $urandom_range(0, 1), $urandom_range(0, 1), 32'($urandom_range(0, 255)) << 2,
                $urandom_range(0, 1), $urandom_range(0, 3) == 0, 10'($urandom_range(0, 1023)),
                "R4");
        end
        idle(); idle();

        checks++;
        if (q_taken.size() != 0) begin
            errors++;
            $display("FAIL R2 missing results act=%0d exp=0", q_taken.size());
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule